// File: doc/BRIEF.md
# Multi-Line Serial Audio Master Port

This block is the master end of a synchronous serial audio link. It derives a bit clock from the master clock and also produces a frame clock. It then moves 32-bit channel slots over up to four data lines, and all of those lines share the same two clocks. Each line carries either two slots per sample period (64 bit clocks) or four slots (128 bit clocks). On the parallel side the block takes one transmit word per channel. It returns one received word per channel, together with a single-cycle strobe once per frame.

Channel `c` occupies bits `[c*32 +: 32]` of `tx_data` and `rx_data`. Slot `k` of line `n` is channel `n*S + k`, where `S` is the number of slots per line. The configuration inputs are sampled only at frame boundaries, so they may change at run time. They set:
- the rate: bit-clock half period of `HALF_DIV` or `2*HALF_DIV` master cycles;
- the slot count per line;
- the number of lines in use;
- the polarity of the frame-clock edge that opens a frame;
- a 16-bit sample mode.

The sequencer has three states:
- `ST_IDLE` is held during reset. On the first clock after reset it moves to `ST_BCLK_LOW` and loads a frame.
- `ST_BCLK_LOW` holds the bit clock low. When its half period ends, it moves to `ST_BCLK_HIGH` and samples the inputs.
- `ST_BCLK_HIGH` holds the bit clock high. When its half period ends, it returns to `ST_BCLK_LOW`. It either advances the bit index or, after the last bit of the frame, publishes the received words and loads the next frame.

Top module: `tdm_serial_master`

## Requirements
- R1: While reset is low, `bclk` and all `sd_out` are 0, `rx_valid` is 0, and `fsync` equals `cfg_fs_fall`. The first frame starts on the first clock edge after reset is released.
- R2: A frame lasts 128 bit clocks when `cfg_four_slot`=1 and 64 bit clocks when it is 0.
- R3: The bit clock is low for H master cycles and then high for H master cycles. H is `HALF_DIV` when the effective rate is high and `2*HALF_DIV` otherwise.
- R4: If `cfg_four_slot`=1 and `cfg_all_lines`=1, `cfg_rate_hi` is ignored and the low rate is used.
- R5: With `cfg_fs_fall`=0, `fsync` is 1 during the first half of the frame's bit periods and 0 during the second half. With `cfg_fs_fall`=1 it is inverted. `fsync` changes only when `bclk` falls.
- R6: Each slot is sent MSB first: bit 31 goes out in the slot's first bit period. Line outputs change only when `bclk` falls. Slot k of line n carries channel n*S+k.
- R7: With `cfg_half_word`=1, the last 16 bit periods of every slot (bits 15..0) are driven 0, and bits 31..16 carry the channel word's upper half.
- R8: With `cfg_all_lines`=0, only line 0 is used. `sd_out[3:1]` stay 0, and their inputs are ignored: the channels mapped to those lines read as 0.
- R9: `sd_in` is sampled on the master edge where `bclk` rises. One master cycle after the frame's last bit ends, `rx_data` holds every slot word, with unused channels 0, and `rx_valid` pulses for one cycle.
- R10: `tx_data` and all configuration inputs are taken at the frame boundary. A change during a frame only affects the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rate_hi | input | 1 | 1 selects the high rate (short bit clock) |
| cfg_four_slot | input | 1 | 1 selects four slots per line, 0 selects two |
| cfg_all_lines | input | 1 | 1 uses all lines, 0 uses only line 0 |
| cfg_fs_fall | input | 1 | 1 makes the falling frame-clock edge open the frame |
| cfg_half_word | input | 1 | 1 selects 16-bit samples with zero low bits |
| tx_data | input | LINES*128 | Transmit word per channel |
| rx_data | output | LINES*128 | Received word per channel |
| rx_valid | output | 1 | One-cycle strobe when rx_data is renewed |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame clock |
| sd_out | output | LINES | Serial transmit data per line |
| sd_in | input | LINES | Serial receive data per line |

## Verification
The assertions check on every cycle that:
- line data and the frame clock change only when the bit clock falls;
- each bit-clock level lasts at least two master cycles;
- idle lines stay low in single-line mode;
- the low bit periods are zero in 16-bit mode;
- the receive strobe never lasts more than one cycle.

Only the bench's scenarios can show the rest: the exact half periods for each rate (including the rejected high rate in the four-by-four setting), the frame length, the channel-to-slot mapping, bit order, the frame-boundary latching of transmit data, and the received words. The bench shows these by following a behavioural model of the waveform through frames with random data.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_BCLK_LOW  = 2'd1,
        ST_BCLK_HIGH = 2'd2
    } seq_state_t;
endpackage

// File: rtl/tdm_seq.sv
module tdm_seq
    import tdm_port_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int BIT_IDX_W = 7,
    parameter int CNT_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_rate_hi,
    input  logic                 cfg_four_slot,
    input  logic                 cfg_all_lines,
    input  logic                 cfg_fs_fall,
    input  logic                 cfg_half_word,
    output seq_state_t           st,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output logic                 four_q,
    output logic                 all_q,
    output logic                 half_q,
    output logic                 bclk,
    output logic                 fsync,
    output logic                 load_en,
    output logic                 sample_en,
    output logic                 frame_end
);
    seq_state_t       st_q, st_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_len;
    logic             cnt_done;
    logic             last_bit;
    logic             first_half;
    logic             rate_q;
    logic             fall_q;

    assign half_len   = rate_q ? CNT_W'(HALF_DIV) : CNT_W'(2 * HALF_DIV);
    assign cnt_done   = (cnt_q == half_len - CNT_W'(1));
    assign last_bit   = (&bit_idx[BIT_IDX_W-2:0]) && (four_q ? bit_idx[BIT_IDX_W-1] : 1'b1);
    assign first_half = four_q ? ~bit_idx[BIT_IDX_W-1] : ~bit_idx[BIT_IDX_W-2];
    assign st         = st_q;

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:      st_nxt = ST_BCLK_LOW;
            ST_BCLK_LOW:  if (cnt_done) st_nxt = ST_BCLK_HIGH;
            ST_BCLK_HIGH: if (cnt_done) st_nxt = ST_BCLK_LOW;
            default:      st_nxt = ST_IDLE;
        endcase
    end

    // state register, divider, bit index and frame configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            bit_idx <= '0;
            four_q  <= 1'b0;
            all_q   <= 1'b0;
            rate_q  <= 1'b0;
            fall_q  <= 1'b0;
            half_q  <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (st_q == ST_IDLE || cnt_done) cnt_q <= '0;
            else                             cnt_q <= cnt_q + CNT_W'(1);
            if (load_en) begin
                bit_idx <= '0;
                four_q  <= cfg_four_slot;
                all_q   <= cfg_all_lines;
                rate_q  <= cfg_rate_hi & ~(cfg_four_slot & cfg_all_lines);
                fall_q  <= cfg_fs_fall;
                half_q  <= cfg_half_word;
            end else if (st_q == ST_BCLK_HIGH && cnt_done) begin
                bit_idx <= bit_idx + BIT_IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        bclk      = (st_q == ST_BCLK_HIGH);
        sample_en = (st_q == ST_BCLK_LOW) && cnt_done;
        frame_end = (st_q == ST_BCLK_HIGH) && cnt_done && last_bit;
        load_en   = (st_q == ST_IDLE) || frame_end;
        fsync     = (st_q == ST_IDLE) ? cfg_fs_fall : (first_half ^ fall_q);
    end
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
    parameter int SLOT_W     = 32,
    parameter int MAX_SLOTS  = 4,
    parameter int BIS_W      = 5,
    parameter int SLOT_IDX_W = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_en,
    input  logic                              line_on,
    input  logic                              half_mode,
    input  logic [MAX_SLOTS-1:0][SLOT_W-1:0]  words_in,
    input  logic [SLOT_IDX_W-1:0]             slot,
    input  logic [BIS_W-1:0]                  bis,
    output logic                              sd
);
    logic [MAX_SLOTS-1:0][SLOT_W-1:0] words_q;
    logic                             on_q;
    logic [BIS_W-1:0]                 pos;
    logic                             low_half;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
            on_q    <= 1'b0;
        end else if (load_en) begin
            words_q <= words_in;
            on_q    <= line_on;
        end
    end

    assign pos      = BIS_W'(SLOT_W - 1) - bis;
    assign low_half = (pos < BIS_W'(SLOT_W / 2));
    assign sd       = on_q & ~(half_mode & low_half) & words_q[slot][pos];
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
    parameter int SLOT_W     = 32,
    parameter int MAX_SLOTS  = 4,
    parameter int BIS_W      = 5,
    parameter int SLOT_IDX_W = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sample_en,
    input  logic                              line_on,
    input  logic                              sd,
    input  logic [SLOT_IDX_W-1:0]             slot,
    input  logic [BIS_W-1:0]                  bis,
    output logic [MAX_SLOTS-1:0][SLOT_W-1:0]  words_out
);
    logic [SLOT_W-2:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            words_out <= '0;
        end else if (sample_en) begin
            shreg <= {shreg[SLOT_W-3:0], sd};
            if (bis == BIS_W'(SLOT_W - 1))
                words_out[slot] <= line_on ? {shreg, sd} : '0;
        end
    end
endmodule

// File: rtl/tdm_serial_master.sv
module tdm_serial_master
    import tdm_port_pkg::*;
#(
    parameter int LINES    = 4,
    parameter int SLOT_W   = 32,
    parameter int HALF_DIV = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_rate_hi,
    input  logic                         cfg_four_slot,
    input  logic                         cfg_all_lines,
    input  logic                         cfg_fs_fall,
    input  logic                         cfg_half_word,
    input  logic [LINES*4*SLOT_W-1:0]    tx_data,
    output logic [LINES*4*SLOT_W-1:0]    rx_data,
    output logic                         rx_valid,
    output logic                         bclk,
    output logic                         fsync,
    output logic [LINES-1:0]             sd_out,
    input  logic [LINES-1:0]             sd_in
);
    localparam int MAX_SLOTS  = 4;
    localparam int SLOT_IDX_W = $clog2(MAX_SLOTS);
    localparam int CH         = LINES * MAX_SLOTS;
    localparam int CH_W       = $clog2(CH);
    localparam int BIS_W      = $clog2(SLOT_W);
    localparam int BIT_IDX_W  = BIS_W + SLOT_IDX_W;
    localparam int CNT_W      = $clog2(2 * HALF_DIV + 1);

    seq_state_t                      seq_st;
    logic [BIT_IDX_W-1:0]            bit_idx;
    logic                            four_q, all_q, half_q;
    logic                            load_en, sample_en, frame_end;
    logic [SLOT_IDX_W-1:0]           slot;
    logic [BIS_W-1:0]                bis;
    int                              slots_in, slots_q;
    logic [CH-1:0][SLOT_W-1:0]       tx_w;
    logic [CH-1:0][SLOT_W-1:0]       rx_next, rx_q;
    logic [MAX_SLOTS-1:0][SLOT_W-1:0] rx_lane [LINES];

    tdm_seq #(
        .HALF_DIV (HALF_DIV),
        .BIT_IDX_W(BIT_IDX_W),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_rate_hi  (cfg_rate_hi),
        .cfg_four_slot(cfg_four_slot),
        .cfg_all_lines(cfg_all_lines),
        .cfg_fs_fall  (cfg_fs_fall),
        .cfg_half_word(cfg_half_word),
        .st           (seq_st),
        .bit_idx      (bit_idx),
        .four_q       (four_q),
        .all_q        (all_q),
        .half_q       (half_q),
        .bclk         (bclk),
        .fsync        (fsync),
        .load_en      (load_en),
        .sample_en    (sample_en),
        .frame_end    (frame_end)
    );

    assign slot     = bit_idx[BIT_IDX_W-1 -: SLOT_IDX_W];
    assign bis      = bit_idx[BIS_W-1:0];
    assign slots_in = cfg_four_slot ? 4 : 2;
    assign slots_q  = four_q ? 4 : 2;
    assign tx_w     = tx_data;

    for (genvar n = 0; n < LINES; n++) begin : g_lane
        logic [MAX_SLOTS-1:0][SLOT_W-1:0] lane_tx;
        logic                             on_next, on_now;

        assign on_next = (n == 0) | cfg_all_lines;
        assign on_now  = (n == 0) | all_q;

        always_comb begin
            lane_tx = '0;
            for (int k = 0; k < MAX_SLOTS; k++)
                if (k < slots_in) lane_tx[k] = tx_w[CH_W'(n * slots_in + k)];
        end

        tdm_tx_lane #(
            .SLOT_W(SLOT_W), .MAX_SLOTS(MAX_SLOTS), .BIS_W(BIS_W), .SLOT_IDX_W(SLOT_IDX_W)
        ) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (load_en),
            .line_on  (on_next),
            .half_mode(half_q),
            .words_in (lane_tx),
            .slot     (slot),
            .bis      (bis),
            .sd       (sd_out[n])
        );

        tdm_rx_lane #(
            .SLOT_W(SLOT_W), .MAX_SLOTS(MAX_SLOTS), .BIS_W(BIS_W), .SLOT_IDX_W(SLOT_IDX_W)
        ) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_en(sample_en),
            .line_on  (on_now),
            .sd       (sd_in[n]),
            .slot     (slot),
            .bis      (bis),
            .words_out(rx_lane[n])
        );
    end

    // gather lane words into channel order at the end of a frame
    always_comb begin
        rx_next = '0;
        for (int n = 0; n < LINES; n++)
            for (int k = 0; k < MAX_SLOTS; k++)
                if (k < slots_q) rx_next[CH_W'(n * slots_q + k)] = rx_lane[n][k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= frame_end;
            if (frame_end) rx_q <= rx_next;
        end
    end

    assign rx_data = rx_q;
endmodule

// File: rtl/tdm_port_checker.sv
module tdm_port_checker
    import tdm_port_pkg::*;
#(
    parameter int LINES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk,
    input logic             fsync,
    input logic [LINES-1:0] sd_out,
    input logic             rx_valid,
    input seq_state_t       st,
    input logic             all_q,
    input logic             half_q,
    input logic             bis_msb
);
    assert_bclk_high_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |=> bclk);

    assert_bclk_low_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk) |=> !bclk);

    assert_fsync_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) && ($past(st) != ST_IDLE) && !$stable(fsync) |-> $fell(bclk));

    assert_data_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) && ($past(st) != ST_IDLE) && !$stable(sd_out) |-> $fell(bclk));

    assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) && half_q && bis_msb |-> (sd_out == '0));

    if (LINES > 1) begin : g_single
        assert_idle_lines_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (st != ST_IDLE) && !all_q |-> (sd_out[LINES-1:1] == '0));
    end

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

bind tdm_serial_master tdm_port_checker #(.LINES(LINES)) u_port_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk    (bclk),
    .fsync   (fsync),
    .sd_out  (sd_out),
    .rx_valid(rx_valid),
    .st      (seq_st),
    .all_q   (all_q),
    .half_q  (half_q),
    .bis_msb (bit_idx[BIS_W-1])
);

// File: tb/tdm_serial_master_bench.sv
module tdm_serial_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 4;
    localparam int SLOT_W     = 32;
    localparam int HALF_DIV   = 2;
    localparam int CH         = LINES * 4;
    localparam int DW         = CH * SLOT_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_rate_hi = 1'b0, cfg_four_slot = 1'b0, cfg_all_lines = 1'b0;
    logic            cfg_fs_fall = 1'b0, cfg_half_word = 1'b0;
    logic [DW-1:0]   tx_data = '0;
    logic [DW-1:0]   rx_data;
    logic            rx_valid, bclk, fsync;
    logic [LINES-1:0] sd_out;
    logic [LINES-1:0] sd_in = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit chk_on   = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tdm_serial_master #(.LINES(LINES), .SLOT_W(SLOT_W), .HALF_DIV(HALF_DIV)) u_tdm_serial_master (
        .clk(clk), .rst_n(rst_n),
        .cfg_rate_hi(cfg_rate_hi), .cfg_four_slot(cfg_four_slot), .cfg_all_lines(cfg_all_lines),
        .cfg_fs_fall(cfg_fs_fall), .cfg_half_word(cfg_half_word),
        .tx_data(tx_data), .rx_data(rx_data), .rx_valid(rx_valid),
        .bclk(bclk), .fsync(fsync), .sd_out(sd_out), .sd_in(sd_in)
    );

    // ---------------- behavioural reference model ----------------
    bit          run = 0;
    int          t = 0;
    bit          m_four, m_all, m_rhi, m_fall, m_half;
    logic [31:0] m_tx  [CH];
    logic [31:0] m_acc [CH];
    logic [31:0] m_rx  [CH];
    bit          exp_valid = 0;
    int          frames_seen = 0;

    function automatic int hl();
        return m_rhi ? HALF_DIV : 2 * HALF_DIV;
    endfunction
    function automatic int fbits();
        return m_four ? 128 : 64;
    endfunction
    function automatic int spl();
        return m_four ? 4 : 2;
    endfunction

    function automatic void load_frame();
        m_four = cfg_four_slot;
        m_all  = cfg_all_lines;
        m_rhi  = cfg_rate_hi && !(cfg_four_slot && cfg_all_lines); // R4
        m_fall = cfg_fs_fall;
        m_half = cfg_half_word;
        for (int c = 0; c < CH; c++) begin
            m_tx[c]  = tx_data[c*32 +: 32];                           // R10
            m_acc[c] = '0;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            run = 0; t = 0; exp_valid = 0;
        end else begin
            exp_valid = 0;
            if (!run) begin
                load_frame(); run = 1; t = 0;
            end else begin
                int h, b;
                h = hl();
                b = t / (2 * h);
                if (t % (2 * h) == h - 1) begin
                    for (int n = 0; n < LINES; n++)
                        if (n == 0 || m_all)
                            m_acc[n * spl() + b / 32] = m_acc[n * spl() + b / 32]
                                | (32'(sd_in[n]) << (31 - b % 32));
                end
                if (t == fbits() * 2 * h - 1) begin
                    for (int c = 0; c < CH; c++) m_rx[c] = m_acc[c];
                    exp_valid = 1;
                    frames_seen++;
                    load_frame(); t = 0;
                end else begin
                    t++;
                end
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            logic            e_bclk, e_fs;
            logic [LINES-1:0] e_sd;
            logic [DW-1:0]   e_rx;
            e_sd = '0;
            if (!run) begin
                e_bclk = 1'b0;
                e_fs   = cfg_fs_fall;
            end else begin
                int h, b, pos, c;
                h      = hl();
                b      = t / (2 * h);
                e_bclk = (t % (2 * h)) >= h;
                e_fs   = ((b < fbits() / 2) ? 1'b1 : 1'b0) ^ m_fall;
                pos    = 31 - b % 32;
                for (int n = 0; n < LINES; n++) begin
                    c = n * spl() + b / 32;
                    if ((n == 0 || m_all) && !(m_half && pos < 16))
                        e_sd[n] = m_tx[c][pos];
                end
            end
            if (!rst_n) chk("R1 reset outputs", DW'({bclk, sd_out, rx_valid}), '0);
            chk("R2 R3 R4 bclk", DW'(bclk), DW'(e_bclk));
            chk("R1 R5 fsync", DW'(fsync), DW'(e_fs));
            chk("R6 R7 R8 R10 sd_out", DW'(sd_out), DW'(e_sd));
            chk("R9 rx_valid", DW'(rx_valid), DW'(exp_valid));
            if (exp_valid) begin
                for (int c = 0; c < CH; c++) e_rx[c*32 +: 32] = m_rx[c];
                chk("R8 R9 rx_data", rx_data, e_rx);
            end
        end
    end

    // random serial input on every line, including unused ones
    always begin
        @(posedge clk);
        #1;
        sd_in = LINES'($urandom);
    end

    task automatic rand_tx();
        for (int c = 0; c < CH; c++) tx_data[c*32 +: 32] = $urandom;
    endtask

    task automatic scenario(input bit rhi, input bit four, input bit all, input bit fall, input bit half);
        int start;
        @(posedge clk); #2;
        cfg_rate_hi = rhi; cfg_four_slot = four; cfg_all_lines = all;
        cfg_fs_fall = fall; cfg_half_word = half;
        rand_tx();
        start = frames_seen;
        wait (frames_seen >= start + 2);
        // mid-frame change: must only show in the following frame (R10)
        repeat (150) @(posedge clk);
        #2 rand_tx();
        wait (frames_seen >= start + 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 chk_on = 1;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        scenario(0, 0, 0, 0, 0);   // two slots, one line, low rate
        scenario(1, 0, 1, 1, 0);   // two slots, all lines, high rate, falling edge
        scenario(1, 1, 0, 0, 1);   // four slots, one line, high rate, 16-bit
        scenario(1, 1, 1, 0, 0);   // four by four: high rate rejected (R4)
        scenario(0, 1, 1, 1, 1);   // four by four, falling edge, 16-bit
        scenario(1, 0, 0, 1, 1);   // back to two slots, single line
        repeat (10) @(posedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired at %0t: actual=running expected=done", $time);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule